// File: doc/BRIEF.md
# VGA 1024x384 Raster Timing Generator

This block produces the scan timing for a 1024-pixel by 384-line visible image on a 40 MHz pixel clock. The complete raster is 1295 clocks per line and 428 lines per frame, which gives a refresh rate of about 72 Hz. It drives active-low horizontal and vertical sync pulses and an active-video flag. It also reports the coordinates of the current pixel and gives a one-clock pulse when each frame ends.

The beam moves from the upper-left corner of the image and scans it line by line. The reported coordinates are mirrored, so the origin (0,0) is the lower-right visible pixel. Downstream logic such as object overlays and colour mixing compares its own positions against `x_pos` and `y_pos`. That logic uses `frame_end` to update its state once per frame. Every segment length is a parameter, and the defaults give the 1024x384 timing.

Top module: `vga_raster_gen`

## Requirements
- R1: The horizontal counter advances on every pixel clock and wraps after H_TOTAL = 1295 clocks (defaults), so hsync falls exactly once every 1295 clocks.
- R2: Within a line, counted from 0 after the wrap, the order is: 1024 active columns, 32 blank columns, 156 columns with hsync_n low (columns 1056 to 1211), then 83 blank columns. Everywhere else in the line hsync_n is high.
- R3: The vertical counter advances once each time the horizontal counter wraps and itself wraps after 428 lines, so frames repeat every 1295*428 clocks.
- R4: Within a frame the order is: 384 active lines, 10 blank lines, 2 lines with vsync_n low for the whole line (lines 394 and 395), then 32 blank lines.
- R5: active is 1 exactly when the column is below 1024 and the line is below 384.
- R6: While active is 1, x_pos = 1023 - column and y_pos = 383 - line, so the origin is the lower-right visible pixel. While active is 0, both outputs are 0.
- R7: frame_end is high for exactly one clock per frame, on column 1294 of line 427. It is low at all other times.
- R8: A synchronous reset puts both counters at zero. Column 0 of line 0 then shows: hsync_n = 1, vsync_n = 1, active = 1, x_pos = 1023, y_pos = 383, frame_end = 0. The first clock after reset is released moves to column 1.
- R9: All eight segment lengths are parameters. The behaviour in R1 to R8 scales with them, and the defaults are the values given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High while the beam is inside the visible image |
| x_pos | output | $clog2(H_ACTIVE) (10) | Mirrored column, 0 at the right edge |
| y_pos | output | $clog2(V_ACTIVE) (9) | Mirrored line, 0 at the bottom edge |
| frame_end | output | 1 | One-clock pulse on the last pixel clock of the frame |

## Verification
The block's only inputs are the clock and the reset. The assertions therefore assume only that reset is driven to a known level from time zero and is held for at least one clock edge before it is released. The step checks on the coordinates are skipped for the cycle that follows reset.

The stimulus meets these assumptions. It starts with reset asserted for several edges and changes reset only on falling clock edges. It releases reset for long runs and injects reset pulses of random length at random points, each lasting at least one full clock.

// File: rtl/vga_raster_gen.sv
module vga_raster_gen #(
  parameter int H_ACTIVE = 1024,
  parameter int H_RIGHT  = 32,
  parameter int H_SYNC   = 156,
  parameter int H_LEFT   = 83,
  parameter int V_ACTIVE = 384,
  parameter int V_BOTTOM = 10,
  parameter int V_SYNC   = 2,
  parameter int V_TOP    = 32,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic [XW-1:0] x_pos,
  output logic [YW-1:0] y_pos,
  output logic          frame_end
);

  localparam int H_TOTAL = H_ACTIVE + H_RIGHT + H_SYNC + H_LEFT;
  localparam int V_TOTAL = V_ACTIVE + V_BOTTOM + V_SYNC + V_TOP;
  localparam int HCW     = $clog2(H_TOTAL);
  localparam int VCW     = $clog2(V_TOTAL);
  localparam int HS_BEG  = H_ACTIVE + H_RIGHT;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_ACTIVE + V_BOTTOM;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           line_last;
  logic           frame_last;
  logic           h_vis;
  logic           v_vis;

  assign line_last  = (hcnt == HCW'(H_TOTAL - 1));
  assign frame_last = (vcnt == VCW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_last ? '0 : hcnt + 1'b1;
      if (line_last)
        vcnt <= frame_last ? '0 : vcnt + 1'b1;
    end
  end

  assign h_vis = (hcnt < HCW'(H_ACTIVE));
  assign v_vis = (vcnt < VCW'(V_ACTIVE));

  assign hsync_n   = !((hcnt >= HCW'(HS_BEG)) && (hcnt < HCW'(HS_END)));
  assign vsync_n   = !((vcnt >= VCW'(VS_BEG)) && (vcnt < VCW'(VS_END)));
  assign active    = h_vis && v_vis;
  assign frame_end = line_last && frame_last;
  assign x_pos     = active ? (XW'(H_ACTIVE - 1) - hcnt[XW-1:0]) : '0;
  assign y_pos     = active ? (YW'(V_ACTIVE - 1) - vcnt[YW-1:0]) : '0;

endmodule

// File: rtl/vga_raster_gen_chk.sv
module vga_raster_gen_chk #(
  parameter int H_ACTIVE = 1024,
  parameter int V_ACTIVE = 384,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          active,
  input logic [XW-1:0] x_pos,
  input logic [YW-1:0] y_pos,
  input logic          frame_end
);

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (hsync_n && vsync_n && active && !frame_end &&
             x_pos == XW'(H_ACTIVE - 1) && y_pos == YW'(V_ACTIVE - 1)));

  p_x_step_r6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(rst)) |-> (x_pos == XW'($past(x_pos) - 1'b1)));

  p_y_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(rst)) |-> (y_pos == $past(y_pos)));

  p_hsync_blank_r2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !active);

  p_vsync_blank_r4: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !active);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  p_strobe_place_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (!active && hsync_n && vsync_n));

endmodule

bind vga_raster_gen vga_raster_gen_chk #(
  .H_ACTIVE(H_ACTIVE),
  .V_ACTIVE(V_ACTIVE)
) u_chk (
  .clk(clk),
  .rst(rst),
  .hsync_n(hsync_n),
  .vsync_n(vsync_n),
  .active(active),
  .x_pos(x_pos),
  .y_pos(y_pos),
  .frame_end(frame_end)
);

// File: tb/sim_vga_raster_gen.sv
module sim_vga_raster_gen;
  localparam int CLK_PERIOD = 25;
  localparam int RUN_CYCLES = 6000;
  localparam int WATCHDOG   = 20000;

  // small raster for full-frame coverage (R9)
  localparam int SHA = 16, SHR = 3, SHS = 5, SHL = 4;
  localparam int SVA = 6,  SVB = 2, SVS = 2, SVT = 3;
  // default raster
  localparam int DHA = 1024, DHR = 32, DHS = 156, DHL = 83;
  localparam int DVA = 384,  DVB = 10, DVS = 2,  DVT = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic       s_hs, s_vs, s_act, s_fe;
  logic [3:0] s_x;
  logic [2:0] s_y;
  logic       d_hs, d_vs, d_act, d_fe;
  logic [9:0] d_x;
  logic [8:0] d_y;

  vga_raster_gen #(
    .H_ACTIVE(SHA), .H_RIGHT(SHR), .H_SYNC(SHS), .H_LEFT(SHL),
    .V_ACTIVE(SVA), .V_BOTTOM(SVB), .V_SYNC(SVS), .V_TOP(SVT)
  ) u0 (
    .clk(clk), .rst(rst), .hsync_n(s_hs), .vsync_n(s_vs), .active(s_act),
    .x_pos(s_x), .y_pos(s_y), .frame_end(s_fe)
  );

  vga_raster_gen u_dflt (
    .clk(clk), .rst(rst), .hsync_n(d_hs), .vsync_n(d_vs), .active(d_act),
    .x_pos(d_x), .y_pos(d_y), .frame_end(d_fe)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // expected outputs from the requirements, given cycles since reset
  task automatic model(input int cyc, input int ha, hr, hs, hl, va, vb, vs, vt,
                       output int ehs, evs, eact, ex, ey, efe);
    int ht, vtot, h, v;
    ht   = ha + hr + hs + hl;
    vtot = va + vb + vs + vt;
    h    = cyc % ht;
    v    = (cyc / ht) % vtot;
    ehs  = (h >= ha + hr && h < ha + hr + hs) ? 0 : 1;
    evs  = (v >= va + vb && v < va + vb + vs) ? 0 : 1;
    eact = (h < ha && v < va) ? 1 : 0;
    ex   = eact ? (ha - 1 - h) : 0;
    ey   = eact ? (va - 1 - v) : 0;
    efe  = (h == ht - 1 && v == vtot - 1) ? 1 : 0;
  endtask

  task automatic check_all(input string tag, input int cyc, input int ha, hr, hs, hl,
                           input int va, vb, vs, vt, input int ghs, gvs, gact, gx, gy, gfe);
    int ehs, evs, eact, ex, ey, efe;
    model(cyc, ha, hr, hs, hl, va, vb, vs, vt, ehs, evs, eact, ex, ey, efe);
    check({tag, " R2"}, "hsync_n", ghs, ehs);
    check({tag, " R4"}, "vsync_n", gvs, evs);
    check({tag, " R5"}, "active", gact, eact);
    check({tag, " R6"}, "x_pos", gx, ex);
    check({tag, " R6"}, "y_pos", gy, ey);
    check({tag, " R7"}, "frame_end", gfe, efe);
  endtask

  initial begin
    int cyc;
    int s_last_fall, d_last_fall, s_last_fe, s_fe_seen;
    bit s_prev_hs, d_prev_hs, rst_next;
    int rst_left;
    void'($urandom(32'd20041110));
    cyc = 0; s_last_fall = -1; d_last_fall = -1; s_last_fe = -1; s_fe_seen = 0;
    s_prev_hs = 1; d_prev_hs = 1; rst_left = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < RUN_CYCLES; n++) begin
      if (rst) begin
        check("R8", "reset hsync_n", int'(s_hs), 1);
        check("R8", "reset vsync_n", int'(d_vs), 1);
        check("R8", "reset x_pos", int'(d_x), 1023);
        check("R8", "reset y_pos", int'(d_y), 383);
      end
      check_all("R9 small", cyc, SHA, SHR, SHS, SHL, SVA, SVB, SVS, SVT,
                s_hs, s_vs, s_act, int'(s_x), int'(s_y), s_fe);
      check_all("R9 default", cyc, DHA, DHR, DHS, DHL, DVA, DVB, DVS, DVT,
                d_hs, d_vs, d_act, int'(d_x), int'(d_y), d_fe);
      if (rst) begin
        s_last_fall = -1; d_last_fall = -1; s_last_fe = -1;
      end else begin
        if (s_prev_hs && !s_hs) begin
          if (s_last_fall >= 0) check("R1", "small line period", cyc - s_last_fall, SHA+SHR+SHS+SHL);
          s_last_fall = cyc;
        end
        if (d_prev_hs && !d_hs) begin
          if (d_last_fall >= 0) check("R1", "default line period", cyc - d_last_fall, 1295);
          d_last_fall = cyc;
        end
        if (s_fe) begin
          s_fe_seen++;
          if (s_last_fe >= 0)
            check("R3", "frame period", cyc - s_last_fe,
                  (SHA+SHR+SHS+SHL) * (SVA+SVB+SVS+SVT));
          s_last_fe = cyc;
        end
      end
      s_prev_hs = s_hs; d_prev_hs = d_hs;
      // reset schedule: directed mid-run pulse plus random pulses
      if (rst_left > 0) rst_left--;
      else if (n == 3000) rst_left = 1;
      else if (n > 1500 && ($urandom % 700) == 0) rst_left = 1 + ($urandom % 3);
      rst_next = (n < 2) || (rst_left > 0);
      rst = rst_next;
      cyc = rst_next ? 0 : cyc + 1;
      @(negedge clk);
    end
    check("R7", "frames seen (>=2)", (s_fe_seen >= 2) ? 1 : 0, 1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule